// File: doc/BRIEF.md
# Dual-Mode Conversion Output Register

This block sits between a sampling converter core and a parallel host bus. It keeps the most recent formatted conversion result in an output register. A two-bit mode input selects the event that copies a finished result into that register. In immediate mode the copy happens as soon as the converter signals that it is done. In deferred mode the finished result waits in a staging register. It moves to the output register when the next conversion is started, so the bus always shows the sample before the one in progress.

The conversion-start strobe (active low) and the busy flag arrive asynchronously. Each passes through a two-flop synchroniser, and its edges are found in clocked logic. Chip-select and read-strobe, both active low, gate a bus output enable. Hosts that keep both tied low see the output register on the bus at all times. The two unused mode encodings raise an error flag. While that flag is high the block freezes both registers.

Top module: `conv_out_reg`

## Requirements
- R1: After reset the output and staging registers hold zero, so with both strobes low `data_out` reads 0. A deferred-mode start edge that arrives before any result has been staged also gives 0.
- R2: With `mode_sel` = 2'b01 (immediate), a rising edge of `busy` copies `result_in` into the output register. The new value appears on the third rising clock edge after `busy` changes: two synchroniser flops, then the register.
- R3: In immediate mode a falling edge of `conv_start_n` leaves the output register unchanged.
- R4: With `mode_sel` = 2'b10 (deferred), a rising edge of `busy` copies `result_in` into the staging register and leaves the output unchanged. The next falling edge of `conv_start_n` moves the staged value to the output. If several results complete between starts, only the latest is kept.
- R5: In deferred mode, changes on `result_in` after the `busy` rising edge do not alter the staged value.
- R6: `mode_sel` values 2'b00 and 2'b11 drive `mode_err` high, and 0 for the legal values. While `mode_err` is high, `busy` and `conv_start_n` edges change neither register.
- R7: When a legal mode returns, updates resume. The staging register still holds the value it had before the illegal period, and immediate-mode loads never write it.
- R8: `data_oe` is high only while `cs_n` and `rd_n` are both low. While it is low, `data_out` is driven to zero.
- R9: Falling edges of `busy` and rising edges of `conv_start_n` never change either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_n | input | 1 | Conversion-start strobe, active low, asynchronous |
| busy | input | 1 | Conversion in progress, asynchronous; rising edge marks completion |
| result_in | input | DATA_W | Formatted result from the converter core |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| mode_sel | input | 2 | {mode2, mode1}: 01 immediate, 10 deferred, others illegal |
| data_out | output | DATA_W | Bus data, zero when not enabled |
| data_oe | output | 1 | Tristate enable for the bus pads |
| mode_err | output | 1 | Illegal mode encoding present |

## Verification
The bench goes after the one-sample lag in deferred mode. A design that loaded the output on the busy edge in both modes would show the new result one step early. One that kept no staging copy would show whatever `result_in` carries when the start edge arrives. The bench also checks that the staged value survives an illegal-mode period and a stretch of immediate-mode operation. A design that kept loading during illegal modes, or shared one register between both paths, would then surface a stale or foreign value. Finally, it counts the exact clock edge of an immediate load and tries busy fall and start rise edges, which a design detecting the wrong polarity would act on.

// File: rtl/cor_pkg.sv
package cor_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_IMM = 2'b01,
    MODE_DEF = 2'b10,
    MODE_BAD = 2'b11
  } cor_mode_e;

  // Only the two one-hot encodings are usable.
  function automatic logic mode_is_legal(input logic [1:0] m);
    return m[1] ^ m[0];
  endfunction

  function automatic logic bus_enabled(input logic cs_n, input logic rd_n);
    return ~(cs_n | rd_n);
  endfunction

endpackage

// File: rtl/cor_edge_sync.sv
module cor_edge_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= IDLE;
    else        chain_q[0] <= async_in;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= IDLE;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise =  chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] &  prev_q;

endmodule

// File: rtl/cor_load_ctrl.sv
module cor_load_ctrl
  import cor_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       busy_rise,
  input  logic       start_fall,
  output logic       load_out_now,
  output logic       load_stage,
  output logic       load_out_stage,
  output logic       mode_err
);

  cor_mode_e mode;

  always_comb begin
    mode           = cor_mode_e'(mode_sel);
    mode_err       = ~mode_is_legal(mode_sel);
    load_out_now   = 1'b0;
    load_stage     = 1'b0;
    load_out_stage = 1'b0;
    unique case (mode)
      MODE_IMM: load_out_now = busy_rise;
      MODE_DEF: begin
        load_stage     = busy_rise;
        load_out_stage = start_fall;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cor_bus_drive.sv
module cor_bus_drive
  import cor_pkg::*;
#(
  parameter int DATA_W = 15
) (
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] reg_val,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);

  assign data_oe  = bus_enabled(cs_n, rd_n);
  assign data_out = data_oe ? reg_val : '0;

endmodule

// File: rtl/conv_out_reg.sv
module conv_out_reg #(
  parameter int DATA_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start_n,
  input  logic              busy,
  input  logic [DATA_W-1:0] result_in,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic [1:0]        mode_sel,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              mode_err
);

  logic              busy_rise, busy_fall;
  logic              start_rise, start_fall;
  logic              load_out_now, load_stage, load_out_stage;
  logic [DATA_W-1:0] stage_q, out_q;

  cor_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_busy_sync (
    .clk(clk), .rst_n(rst_n), .async_in(busy),
    .rise(busy_rise), .fall(busy_fall)
  );

  cor_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_start_sync (
    .clk(clk), .rst_n(rst_n), .async_in(conv_start_n),
    .rise(start_rise), .fall(start_fall)
  );

  cor_load_ctrl u_ctrl (
    .mode_sel(mode_sel), .busy_rise(busy_rise), .start_fall(start_fall),
    .load_out_now(load_out_now), .load_stage(load_stage),
    .load_out_stage(load_out_stage), .mode_err(mode_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stage_q <= '0;
    else if (load_stage) stage_q <= result_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              out_q <= '0;
    else if (load_out_now)   out_q <= result_in;
    else if (load_out_stage) out_q <= stage_q;
  end

  cor_bus_drive #(.DATA_W(DATA_W)) u_bus (
    .cs_n(cs_n), .rd_n(rd_n), .reg_val(out_q),
    .data_out(data_out), .data_oe(data_oe)
  );

  // Trailing edges are detected but deliberately unused by the loads.
  logic unused_edges;
  assign unused_edges = busy_fall ^ start_rise;

endmodule

// File: rtl/cor_checker.sv
module cor_checker #(
  parameter int DATA_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_sel,
  input logic              cs_n,
  input logic              rd_n,
  input logic [DATA_W-1:0] result_in,
  input logic [DATA_W-1:0] data_out,
  input logic              data_oe,
  input logic              mode_err,
  input logic              busy_rise,
  input logic              start_fall,
  input logic [DATA_W-1:0] stage_q,
  input logic [DATA_W-1:0] out_q
);

  p_imm_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && busy_rise) |=> out_q == $past(result_in));

  p_imm_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && start_fall && !busy_rise) |=> $stable(out_q));

  p_def_transfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && start_fall) |=> out_q == $past(stage_q));

  p_def_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && busy_rise) |=> stage_q == $past(result_in));

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> ($stable(out_q) && $stable(stage_q)));

  p_stage_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b10) |=> $stable(stage_q));

  p_bus_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (!data_oe && data_out == '0));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_rise && !start_fall) |=> ($stable(out_q) && $stable(stage_q)));

endmodule

bind conv_out_reg cor_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .rd_n(rd_n),
  .result_in(result_in), .data_out(data_out), .data_oe(data_oe),
  .mode_err(mode_err), .busy_rise(busy_rise), .start_fall(start_fall),
  .stage_q(stage_q), .out_q(out_q)
);

// File: tb/conv_out_reg_test.sv
module conv_out_reg_test;

  localparam int W = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         conv_start_n = 1'b1;
  logic         busy = 1'b0;
  logic [W-1:0] result_in = '0;
  logic         cs_n = 1'b0;
  logic         rd_n = 1'b0;
  logic [1:0]   mode_sel = 2'b01;
  logic [W-1:0] data_out;
  logic         data_oe;
  logic         mode_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  conv_out_reg #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n), .busy(busy),
    .result_in(result_in), .cs_n(cs_n), .rd_n(rd_n), .mode_sel(mode_sel),
    .data_out(data_out), .data_oe(data_oe), .mode_err(mode_err)
  );

  // {mode[1:0], op (0 busy pulse, 1 start pulse), value[14:0], expected[14:0]}
  localparam int NV = 13;
  localparam logic [32:0] VEC [0:NV-1] = '{
    {2'b01, 1'b0, 15'h1234, 15'h1234},  // R2
    {2'b01, 1'b1, 15'h0000, 15'h1234},  // R3
    {2'b10, 1'b0, 15'h0AAA, 15'h1234},  // R4 staged only
    {2'b10, 1'b1, 15'h0000, 15'h0AAA},  // R4/R5 transfer
    {2'b10, 1'b0, 15'h7FFF, 15'h0AAA},  // R4
    {2'b10, 1'b0, 15'h0001, 15'h0AAA},  // R4 overwrite stage
    {2'b10, 1'b1, 15'h0000, 15'h0001},  // R4 latest kept
    {2'b00, 1'b0, 15'h5555, 15'h0001},  // R6
    {2'b11, 1'b1, 15'h0000, 15'h0001},  // R6
    {2'b10, 1'b1, 15'h0000, 15'h0001},  // R7 stage untouched
    {2'b01, 1'b0, 15'h4000, 15'h4000},  // R7 resume
    {2'b11, 1'b0, 15'h2222, 15'h4000},  // R6
    {2'b10, 1'b1, 15'h0000, 15'h0001}   // R7 imm never writes stage
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busy_pulse(input logic [W-1:0] v);
    result_in = v;
    busy = 1'b1;
    wait_clk(4);
    result_in = 15'h3C3C;  // R5: changes after the edge must not be staged
    busy = 1'b0;
    wait_clk(4);
  endtask

  task automatic start_pulse();
    conv_start_n = 1'b0;
    wait_clk(4);
    conv_start_n = 1'b1;
    wait_clk(4);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(3);
    // R1 reset state
    check("R1 data during reset", data_out, '0);
    check("R1 oe during reset", W'(data_oe), W'(1));
    rst_n = 1'b1;
    wait_clk(2);
    check("R1 data after reset", data_out, '0);
    check("R6 err legal mode", W'(mode_err), '0);
    mode_sel = 2'b10;
    start_pulse();
    check("R1 empty stage", data_out, '0);

    // R2 exact latency: output changes on third rising edge
    mode_sel = 2'b01;
    result_in = 15'h0777;
    busy = 1'b1;
    @(negedge clk);
    check("R2 edge1", data_out, '0);
    @(negedge clk);
    check("R2 edge2", data_out, '0);
    @(negedge clk);
    check("R2 edge3", data_out, 15'h0777);
    result_in = 15'h0123;
    busy = 1'b0;
    wait_clk(4);
    check("R9 busy fall", data_out, 15'h0777);
    conv_start_n = 1'b0;
    wait_clk(4);
    mode_sel = 2'b10;
    conv_start_n = 1'b1;
    wait_clk(4);
    check("R9 start rise", data_out, 15'h0777);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      logic [32:0] v;
      v = VEC[k];
      mode_sel = v[32:31];
      wait_clk(1);
      check($sformatf("R6 err flag vec %0d", k), W'(mode_err), W'(v[32] == v[31]));
      if (v[30]) start_pulse();
      else       busy_pulse(v[29:15]);
      check($sformatf("R2-table vec %0d (R3 R4 R5 R6 R7)", k), data_out, v[14:0]);
    end

    // R8 bus enable
    cs_n = 1'b1;
    @(negedge clk);
    check("R8 oe cs high", W'(data_oe), '0);
    check("R8 data cs high", data_out, '0);
    cs_n = 1'b0; rd_n = 1'b1;
    @(negedge clk);
    check("R8 oe rd high", W'(data_oe), '0);
    check("R8 data rd high", data_out, '0);
    rd_n = 1'b0;
    @(negedge clk);
    check("R8 oe both low", W'(data_oe), W'(1));
    check("R8 data both low", data_out, 15'h0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule